// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit sits at the issue point of a 32-bit core and turns exception requests into the state changes needed to enter a handler. Seven request lines are sampled each cycle: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt (IRQ) and fast interrupt (FIQ). The interrupt lines are masked by the current status word. At most one request is granted per cycle, by a fixed priority.

In the cycle a request is accepted, the unit raises a combinational kill line. This line invalidates the operand register reads of the instruction at issue. One clock later, a registered bundle is valid for exactly one cycle. It carries the class taken, the new status word, the target mode, the vector fetch address, a saved-status write with the old status word, and a link-register write.

The link values come from two address inputs. The first is the address of the issuing instruction plus 8. The second is the address of the next instruction to execute, and it is used by interrupts. Instruction decode, the register file, the banked copies and the pipeline flush are handled outside this unit.

Top module: `exc_entry_unit`

## Requirements
- R1: The entry mode code on `entry_mode` and in bits 4:0 of `new_psr` is 10011 for reset and software interrupt, 11011 for undefined, 10111 for prefetch and data abort, 10010 for IRQ and 10001 for FIQ.
- R2: `entry_class` encodes the class taken as 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 6 IRQ, 7 FIQ. `vec_addr` is the base plus four times that code. The base is 0xFFFF0000 when `hivec` is 1 and 0x00000000 when it is 0.
- R3: On every entry, `new_psr` has bit 5 cleared and bit 7 set. Bits 31:8 are copied from `cur_psr`.
- R4: Bit 6 of `new_psr` is set on reset and FIQ entry. For every other class it equals bit 6 of `cur_psr`.
- R5: For every class except reset, `spsr_we` is 1 and `spsr_wdata` equals the `cur_psr` of the accepting cycle. On reset, `spsr_we` and `lr_we` are both 0.
- R6: When `lr_we` is 1, `lr_wdata` has these values: for undefined, software interrupt and prefetch abort, `excp_pc8` minus 4; for data abort, `excp_pc8`; for IRQ and FIQ, `resume_pc` plus 4.
- R7: When requests arrive together, the one granted is chosen in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R8: An IRQ request has no effect while `cur_psr` bit 7 is 1. An FIQ request has no effect while `cur_psr` bit 6 is 1. The other requests are never masked.
- R9: A prefetch-abort request made together with an undefined or software-interrupt request is taken as a prefetch abort.
- R10: The output bundle is valid (`entry_valid` = 1) exactly in the cycle after an acceptance. In other cycles `entry_valid`, `spsr_we` and `lr_we` are 0.
- R11: `opnd_kill` is 1 in the cycle a request is accepted and 0 otherwise. It is combinational.
- R12: While `rst_n` is low, `entry_valid`, `spsr_we` and `lr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort flag of the issuing instruction |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_psr | input | 32 | Current status word |
| excp_pc8 | input | 32 | Address of the issuing instruction plus 8 |
| resume_pc | input | 32 | Address of the next instruction to execute |
| hivec | input | 1 | High vector base select |
| opnd_kill | output | 1 | Invalidate operand reads (acceptance cycle) |
| entry_valid | output | 1 | Registered bundle valid |
| entry_class | output | 3 | Class taken |
| entry_mode | output | 5 | Target mode code |
| new_psr | output | 32 | Status word for the handler |
| spsr_we | output | 1 | Saved-status write enable |
| spsr_wdata | output | 32 | Saved-status write value |
| lr_we | output | 1 | Link-register write enable |
| lr_wdata | output | 32 | Link-register write value |
| vec_addr | output | 32 | Vector fetch address |

## Verification
Each class is driven alone with both vector bases. This separates the per-class mode, slot, link arithmetic and save rules.

Requests are then stacked in pairs and groups. These patterns show whether the fixed order and the prefetch-abort override hold, or whether a lower class leaks through.

Status words with bits 5, 6 and 7 in different states show three things: whether the interrupt masks suppress acceptance, whether bit 6 is preserved or forced, and whether bit 5 is cleared. Back-to-back acceptances, and idle cycles between them, show that the bundle lasts exactly one cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd6,
    EXC_FIQ   = 3'd7
  } exc_class_e;

  localparam int EXC_NUM_SRC = 7;
  localparam int MODE_W      = 5;
  localparam int PSR_T_BIT   = 5;
  localparam int PSR_F_BIT   = 6;
  localparam int PSR_I_BIT   = 7;

  typedef struct packed {
    logic reset;
    logic undef;
    logic swi;
    logic pabt;
    logic dabt;
    logic irq;
    logic fiq;
  } exc_req_t;

  // Priority slot 0 is the highest.
  function automatic exc_class_e slot_class(input int slot);
    case (slot)
      0:       return EXC_RESET;
      1:       return EXC_DABT;
      2:       return EXC_FIQ;
      3:       return EXC_IRQ;
      4:       return EXC_PABT;
      5:       return EXC_UNDEF;
      default: return EXC_SWI;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] entry_mode_of(input exc_class_e c);
    case (c)
      EXC_RESET, EXC_SWI: return 5'b10011;
      EXC_UNDEF:          return 5'b11011;
      EXC_PABT, EXC_DABT: return 5'b10111;
      EXC_IRQ:            return 5'b10010;
      default:            return 5'b10001;
    endcase
  endfunction

  function automatic logic forces_fiq_mask(input exc_class_e c);
    return (c == EXC_RESET) || (c == EXC_FIQ);
  endfunction

  function automatic logic saves_state(input exc_class_e c);
    return c != EXC_RESET;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  exc_req_t                req,
  input  logic                    irq_masked,
  input  logic                    fiq_masked,
  output logic                    fire,
  output logic [EXC_NUM_SRC-1:0]  grant,
  output exc_class_e              cls
);

  logic [EXC_NUM_SRC-1:0] cand;

  // Candidates in priority order, slot 0 first.
  assign cand[0] = req.reset;
  assign cand[1] = req.dabt;
  assign cand[2] = req.fiq & ~fiq_masked;
  assign cand[3] = req.irq & ~irq_masked;
  assign cand[4] = req.pabt;
  assign cand[5] = req.undef;
  assign cand[6] = req.swi;

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < EXC_NUM_SRC; i++) begin
      if (cand[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    cls = EXC_RESET;
    for (int i = 0; i < EXC_NUM_SRC; i++) begin
      if (grant[i]) cls = slot_class(i);
    end
  end

  assign fire = |cand;

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  exc_class_e         cls,
  input  logic [XLEN-1:0]    cur_psr,
  input  logic [XLEN-1:0]    excp_pc8,
  input  logic [XLEN-1:0]    resume_pc,
  input  logic               hivec,
  output logic [MODE_W-1:0]  mode,
  output logic [XLEN-1:0]    new_psr,
  output logic               spsr_we,
  output logic               lr_we,
  output logic [XLEN-1:0]    link,
  output logic [XLEN-1:0]    vec
);

  localparam int SLOT_SHIFT = 2;
  localparam logic [XLEN-1:0] WORD     = XLEN'(4);
  localparam logic [XLEN-1:0] MINUS_WD = ~WORD + XLEN'(1);

  function automatic logic [XLEN-1:0] link_of(input exc_class_e c,
                                              input logic [XLEN-1:0] pc8,
                                              input logic [XLEN-1:0] rpc);
    case (c)
      EXC_UNDEF, EXC_SWI, EXC_PABT: return pc8 + MINUS_WD;
      EXC_DABT:                     return pc8;
      EXC_IRQ, EXC_FIQ:             return rpc + WORD;
      default:                      return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vec_of(input exc_class_e c, input logic hi);
    logic [XLEN-1:0] base;
    base = hi ? XLEN'(HIVEC_BASE) : '0;
    return base | (XLEN'(c) << SLOT_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] psr_of(input exc_class_e c,
                                             input logic [XLEN-1:0] p);
    logic [XLEN-1:0] n;
    n = p;
    n[MODE_W-1:0] = entry_mode_of(c);
    n[PSR_T_BIT]  = 1'b0;
    n[PSR_I_BIT]  = 1'b1;
    if (forces_fiq_mask(c)) n[PSR_F_BIT] = 1'b1;
    return n;
  endfunction

  assign mode    = entry_mode_of(cls);
  assign new_psr = psr_of(cls, cur_psr);
  assign spsr_we = saves_state(cls);
  assign lr_we   = saves_state(cls);
  assign link    = link_of(cls, excp_pc8, resume_pc);
  assign vec     = vec_of(cls, hivec);

endmodule

// File: rtl/exc_out_reg.sv
module exc_out_reg
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  exc_class_e         cls_d,
  input  logic [MODE_W-1:0]  mode_d,
  input  logic [XLEN-1:0]    psr_d,
  input  logic               spsr_we_d,
  input  logic [XLEN-1:0]    spsr_d,
  input  logic               lr_we_d,
  input  logic [XLEN-1:0]    lr_d,
  input  logic [XLEN-1:0]    vec_d,
  output logic               valid_q,
  output exc_class_e         cls_q,
  output logic [MODE_W-1:0]  mode_q,
  output logic [XLEN-1:0]    psr_q,
  output logic               spsr_we_q,
  output logic [XLEN-1:0]    spsr_q,
  output logic               lr_we_q,
  output logic [XLEN-1:0]    lr_q,
  output logic [XLEN-1:0]    vec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      cls_q     <= EXC_RESET;
      mode_q    <= '0;
      psr_q     <= '0;
      spsr_we_q <= 1'b0;
      spsr_q    <= '0;
      lr_we_q   <= 1'b0;
      lr_q      <= '0;
      vec_q     <= '0;
    end else begin
      valid_q   <= fire;
      cls_q     <= fire ? cls_d  : EXC_RESET;
      mode_q    <= fire ? mode_d : '0;
      psr_q     <= fire ? psr_d  : '0;
      spsr_we_q <= fire & spsr_we_d;
      spsr_q    <= (fire & spsr_we_d) ? spsr_d : '0;
      lr_we_q   <= fire & lr_we_d;
      lr_q      <= (fire & lr_we_d) ? lr_d : '0;
      vec_q     <= fire ? vec_d : '0;
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_reset,
  input  logic             req_undef,
  input  logic             req_swi,
  input  logic             req_pabt,
  input  logic             req_dabt,
  input  logic             req_irq,
  input  logic             req_fiq,
  input  logic [XLEN-1:0]  cur_psr,
  input  logic [XLEN-1:0]  excp_pc8,
  input  logic [XLEN-1:0]  resume_pc,
  input  logic             hivec,
  output logic             opnd_kill,
  output logic             entry_valid,
  output logic [2:0]       entry_class,
  output logic [4:0]       entry_mode,
  output logic [XLEN-1:0]  new_psr,
  output logic             spsr_we,
  output logic [XLEN-1:0]  spsr_wdata,
  output logic             lr_we,
  output logic [XLEN-1:0]  lr_wdata,
  output logic [XLEN-1:0]  vec_addr
);

  exc_req_t               req_bus;
  logic                   acc_fire;
  logic [EXC_NUM_SRC-1:0] acc_grant;
  exc_class_e             acc_class;
  logic [MODE_W-1:0]      calc_mode;
  logic [XLEN-1:0]        calc_psr;
  logic                   calc_spsr_we;
  logic                   calc_lr_we;
  logic [XLEN-1:0]        calc_link;
  logic [XLEN-1:0]        calc_vec;
  exc_class_e             q_class;

  assign req_bus = '{reset: req_reset, undef: req_undef, swi: req_swi,
                     pabt: req_pabt, dabt: req_dabt, irq: req_irq, fiq: req_fiq};

  exc_arbiter u_arb (
    .req        (req_bus),
    .irq_masked (cur_psr[PSR_I_BIT]),
    .fiq_masked (cur_psr[PSR_F_BIT]),
    .fire       (acc_fire),
    .grant      (acc_grant),
    .cls        (acc_class)
  );

  exc_state_calc #(.XLEN(XLEN), .HIVEC_BASE(HIVEC_BASE)) u_calc (
    .cls       (acc_class),
    .cur_psr   (cur_psr),
    .excp_pc8  (excp_pc8),
    .resume_pc (resume_pc),
    .hivec     (hivec),
    .mode      (calc_mode),
    .new_psr   (calc_psr),
    .spsr_we   (calc_spsr_we),
    .lr_we     (calc_lr_we),
    .link      (calc_link),
    .vec       (calc_vec)
  );

  exc_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (acc_fire),
    .cls_d     (acc_class),
    .mode_d    (calc_mode),
    .psr_d     (calc_psr),
    .spsr_we_d (calc_spsr_we),
    .spsr_d    (cur_psr),
    .lr_we_d   (calc_lr_we),
    .lr_d      (calc_link),
    .vec_d     (calc_vec),
    .valid_q   (entry_valid),
    .cls_q     (q_class),
    .mode_q    (entry_mode),
    .psr_q     (new_psr),
    .spsr_we_q (spsr_we),
    .spsr_q    (spsr_wdata),
    .lr_we_q   (lr_we),
    .lr_q      (lr_wdata),
    .vec_q     (vec_addr)
  );

  assign entry_class = q_class;
  assign opnd_kill   = acc_fire;

endmodule

// File: rtl/exc_entry_checks.sv
module exc_entry_checks
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_fire,
  input logic [EXC_NUM_SRC-1:0] acc_grant,
  input logic [2:0]             acc_class,
  input logic [XLEN-1:0]        cur_psr,
  input logic                   entry_valid,
  input logic [2:0]             entry_class,
  input logic [4:0]             entry_mode,
  input logic [XLEN-1:0]        new_psr,
  input logic                   spsr_we,
  input logic [XLEN-1:0]        spsr_wdata,
  input logic                   lr_we,
  input logic [XLEN-1:0]        vec_addr
);

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> entry_valid);  // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !entry_valid && !spsr_we && !lr_we);  // R10
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_grant) && (acc_fire == (acc_grant != '0)));  // R7
  AST_PSR_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> !new_psr[PSR_T_BIT] && new_psr[PSR_I_BIT]);  // R3
  AST_MODE_IN_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> new_psr[4:0] == entry_mode);  // R1
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> vec_addr[4:0] == {entry_class, 2'b00});  // R2
  AST_RESET_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid && entry_class == 3'd0 |-> !spsr_we && !lr_we);  // R5
  AST_SPSR_OLD_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid && entry_class != 3'd0 |-> spsr_we && spsr_wdata == $past(cur_psr));  // R5
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_class == 3'd6 |-> !cur_psr[PSR_I_BIT]);  // R8
  AST_FIQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_class == 3'd7 |-> !cur_psr[PSR_F_BIT]);  // R8

endmodule

bind exc_entry_unit exc_entry_checks #(.XLEN(XLEN)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_fire    (acc_fire),
  .acc_grant   (acc_grant),
  .acc_class   (acc_class),
  .cur_psr     (cur_psr),
  .entry_valid (entry_valid),
  .entry_class (entry_class),
  .entry_mode  (entry_mode),
  .new_psr     (new_psr),
  .spsr_we     (spsr_we),
  .spsr_wdata  (spsr_wdata),
  .lr_we       (lr_we),
  .vec_addr    (vec_addr)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r_reset = 0, r_undef = 0, r_swi = 0, r_pabt = 0, r_dabt = 0, r_irq = 0, r_fiq = 0;
  logic [31:0] psr = 0, pc8 = 0, rpc = 0;
  logic hv = 0;
  logic opnd_kill, entry_valid, spsr_we, lr_we;
  logic [2:0] entry_class;
  logic [4:0] entry_mode;
  logic [31:0] new_psr, spsr_wdata, lr_wdata, vec_addr;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_reset(r_reset), .req_undef(r_undef), .req_swi(r_swi), .req_pabt(r_pabt),
    .req_dabt(r_dabt), .req_irq(r_irq), .req_fiq(r_fiq),
    .cur_psr(psr), .excp_pc8(pc8), .resume_pc(rpc), .hivec(hv),
    .opnd_kill(opnd_kill), .entry_valid(entry_valid), .entry_class(entry_class),
    .entry_mode(entry_mode), .new_psr(new_psr), .spsr_we(spsr_we),
    .spsr_wdata(spsr_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata), .vec_addr(vec_addr)
  );

  typedef struct {
    logic        valid;
    logic [2:0]  cls;
    logic [4:0]  mode;
    logic [31:0] psr;
    logic        spsr_we;
    logic [31:0] spsr;
    logic        lr_we;
    logic [31:0] lr;
    logic [31:0] vec;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirement list.
  function automatic exp_t model(input logic rs, un, sw, pa, da, iq, fq,
                                 input logic [31:0] p, c8, rp, input logic h,
                                 input string tag);
    exp_t e;
    logic irq_ok, fiq_ok;
    irq_ok = iq && (p[7] == 1'b0);
    fiq_ok = fq && (p[6] == 1'b0);
    e.tag = tag;
    e.valid = 1'b1;
    if (rs)          e.cls = 3'd0;
    else if (da)     e.cls = 3'd4;
    else if (fiq_ok) e.cls = 3'd7;
    else if (irq_ok) e.cls = 3'd6;
    else if (pa)     e.cls = 3'd3;
    else if (un)     e.cls = 3'd1;
    else if (sw)     e.cls = 3'd2;
    else             e.valid = 1'b0;
    case (e.cls)
      3'd0, 3'd2: e.mode = 5'h13;
      3'd1:       e.mode = 5'h1B;
      3'd3, 3'd4: e.mode = 5'h17;
      3'd6:       e.mode = 5'h12;
      default:    e.mode = 5'h11;
    endcase
    e.psr = {p[31:8], 1'b1, (e.cls == 3'd0 || e.cls == 3'd7) ? 1'b1 : p[6], 1'b0, e.mode};
    e.spsr_we = (e.cls != 3'd0);
    e.spsr = p;
    e.lr_we = (e.cls != 3'd0);
    if (e.cls == 3'd4) e.lr = c8;
    else if (e.cls == 3'd6 || e.cls == 3'd7) e.lr = rp + 32'd4;
    else e.lr = c8 - 32'd4;
    e.vec = (h ? 32'hFFFF_0000 : 32'h0) + {27'd0, e.cls, 2'b00};
    if (!e.valid) begin
      e.spsr_we = 1'b0;
      e.lr_we = 1'b0;
    end
    return e;
  endfunction

  // Driver: one call per cycle; pushes the expected bundle.
  task automatic drive(input logic rs, un, sw, pa, da, iq, fq,
                       input logic [31:0] p, c8, rp, input logic h, input string tag);
    exp_t e;
    @(negedge clk);
    r_reset = rs; r_undef = un; r_swi = sw; r_pabt = pa;
    r_dabt = da; r_irq = iq; r_fiq = fq;
    psr = p; pc8 = c8; rpc = rp; hv = h;
    e = model(rs, un, sw, pa, da, iq, fq, p, c8, rp, h, tag);
    #0.5;
    check(opnd_kill == e.valid, "R11", "opnd_kill", {31'd0, opnd_kill}, {31'd0, e.valid});
    sb_q.push_back(e);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 0, "R10");
  endtask

  // Monitor: pops one expected item per cycle after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(entry_valid == e.valid, e.tag, "entry_valid", {31'd0, entry_valid}, {31'd0, e.valid});
      if (e.valid) begin
        check(entry_class == e.cls, e.tag, "entry_class", {29'd0, entry_class}, {29'd0, e.cls});
        check(entry_mode == e.mode, "R1", "entry_mode", {27'd0, entry_mode}, {27'd0, e.mode});
        check(vec_addr == e.vec, "R2", "vec_addr", vec_addr, e.vec);
        check(new_psr == e.psr, "R3/R4", "new_psr", new_psr, e.psr);
        check(spsr_we == e.spsr_we, "R5", "spsr_we", {31'd0, spsr_we}, {31'd0, e.spsr_we});
        if (e.spsr_we) check(spsr_wdata == e.spsr, "R5", "spsr_wdata", spsr_wdata, e.spsr);
        check(lr_we == e.lr_we, "R5", "lr_we", {31'd0, lr_we}, {31'd0, e.lr_we});
        if (e.lr_we) check(lr_wdata == e.lr, "R6", "lr_wdata", lr_wdata, e.lr);
      end else begin
        check(!spsr_we && !lr_we, e.tag, "write enables idle", {30'd0, spsr_we, lr_we}, 32'd0);
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    r_reset = 1;
    r_fiq = 1;
    repeat (3) @(negedge clk);
    check(!entry_valid && !spsr_we && !lr_we, "R12", "reset outputs",
          {29'd0, entry_valid, spsr_we, lr_we}, 32'd0);
    r_reset = 0;
    r_fiq = 0;
    rst_n = 1;

    idle();
    // Single classes, low and high vector bases.
    drive(1, 0, 0, 0, 0, 0, 0, 32'hA000_0010, 32'h100, 32'h200, 0, "R2");
    drive(0, 1, 0, 0, 0, 0, 0, 32'h6000_0030, 32'h1008, 32'h2000, 1, "R1");
    drive(0, 0, 1, 0, 0, 0, 0, 32'h0000_0050, 32'h3008, 32'h4000, 0, "R6");
    drive(0, 0, 0, 1, 0, 0, 0, 32'h0000_0010, 32'h0000_0004, 32'h0, 1, "R6");
    drive(0, 0, 0, 0, 1, 0, 0, 32'h1234_5610, 32'h8000_0008, 32'h0, 0, "R6");
    drive(0, 0, 0, 0, 0, 1, 0, 32'h0000_0030, 32'h0, 32'hFFFF_FFFC, 1, "R6");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0020, 32'h0, 32'h0000_4444, 0, "R4");
    idle();
    // Masking.
    drive(0, 0, 0, 0, 0, 1, 0, 32'h0000_0090, 32'h0, 32'h10, 0, "R8");
    drive(0, 0, 0, 0, 0, 0, 1, 32'h0000_0050, 32'h0, 32'h10, 0, "R8");
    drive(0, 0, 0, 0, 0, 1, 1, 32'h0000_0050, 32'h0, 32'h10, 1, "R8");
    drive(0, 0, 0, 0, 0, 1, 1, 32'h0000_00D0, 32'h0, 32'h10, 0, "R8");
    drive(0, 1, 0, 0, 0, 0, 0, 32'h0000_00F0, 32'h208, 32'h10, 0, "R8");
    // Priority and override.
    drive(1, 1, 1, 1, 1, 1, 1, 32'h0000_0010, 32'h108, 32'h10, 1, "R7");
    drive(0, 1, 1, 1, 1, 1, 1, 32'h0000_0010, 32'h108, 32'h10, 0, "R7");
    drive(0, 1, 1, 1, 0, 1, 1, 32'h0000_0010, 32'h108, 32'h20, 1, "R7");
    drive(0, 1, 1, 1, 0, 1, 0, 32'h0000_0010, 32'h108, 32'h30, 0, "R7");
    drive(0, 1, 0, 1, 0, 0, 0, 32'h0000_0010, 32'h508, 32'h30, 0, "R9");
    drive(0, 0, 1, 1, 0, 0, 0, 32'h0000_0010, 32'h608, 32'h30, 1, "R9");
    drive(0, 1, 1, 0, 0, 0, 0, 32'h0000_0010, 32'h708, 32'h30, 0, "R7");
    // Bit 6 preserved versus forced.
    drive(0, 0, 1, 0, 0, 0, 0, 32'hFFFF_FF40, 32'h808, 32'h0, 0, "R4");
    drive(1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FF00, 32'h808, 32'h0, 1, "R4");
    idle();
    idle();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule